// File: doc/BRIEF.md
# Ten-Bit Line Serializer with Wrap and Hold States

This block converts ten-bit transmit characters into a serial bit stream in a single fast bit-clock domain. A capture strobe marks the byte-clock edge on which a new character is taken into a four-entry elastic word queue. A separate load strobe, which fires once every ten bit clocks, moves the oldest queued character into an output shift register. The register then emits one bit per clock, least significant bit first, with no idle bits between characters.

The block also controls the serial line itself. During transmit reset, and from power-up until the clock-multiplier lock input has been seen high, both line outputs sit at a fixed state: the true output low and the complement high. In loopback (wrap) mode both line outputs sit high, and the bit stream is sent to a separate internal wrap output instead. The queue starts half full with two all-zero characters. If the fill level ever reaches empty or full, a sticky error flag is set.

Top module: `ser_tx_top`

## Requirements
- R1: After reset or transmit reset, the queue holds two all-zero characters. A character captured on a cycle where the capture and load strobes are both high is first loaded into the shift register on the second later load strobe. So in a steady stream the first two characters on the line are zeros.
- R2: In data mode, the character loaded on a load-strobe edge is output as bit 0 in the following cycle, then bits 1 to 9 in the next nine cycles. line_p carries the bit and line_n carries its complement. Load strobes are never closer together than ten cycles.
- R3: The queue holds four characters. A capture while the queue is full is discarded. A load while the queue is empty puts an all-zero character into the shift register.
- R4: fifo_err goes high on the edge where the fill level becomes 0 or 4. It then stays high until rst_n or tx_rst clears it.
- R5: In wrap mode (wrap_en high, line active), line_p and line_n are both 1 and wrap_ser carries the serial bit. In every other state wrap_ser is 0.
- R6: While tx_rst is high, line_p is 0 and line_n is 1. tx_rst also re-primes the queue, clears the shift register and clears fifo_err.
- R7: After rst_n, the line stays in the hold state (line_p 0, line_n 1) until pll_lock is sampled high on a clock edge. The line becomes active from that edge on. Lock then stays remembered even if pll_lock later falls.
- R8: The hold state takes priority over wrap mode. While unlocked or in transmit reset, wrap_en does not raise line_p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | Byte-clock edge marker: capture tx_word into the queue |
| tx_word | input | 10 | Parallel transmit character, bit 0 sent first |
| ld_stb | input | 1 | Word strobe: load the shift register from the queue |
| tx_rst | input | 1 | Transmit reset, holds the line and re-primes the datapath |
| pll_lock | input | 1 | Clock-multiplier lock indication |
| wrap_en | input | 1 | Loopback enable |
| line_p | output | 1 | Serial line, true output |
| line_n | output | 1 | Serial line, complement output |
| wrap_ser | output | 1 | Serial stream toward the internal receive path |
| fifo_err | output | 1 | Sticky queue empty/full error |

## Verification
The assertions take for granted that ld_stb never fires sooner than ten cycles after the previous load, except across a reset or transmit reset. They also assume the inputs change only away from the active edge. The stimulus drives every strobe through a ten-cycle period task, so load spacing is always a multiple of ten. It starts a fresh stream only after tx_rst or rst_n. Mode inputs (wrap_en, pll_lock, tx_rst) are changed only on falling edges. This lets the monitor judge each bit by the mode that holds while that bit is on the line.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    LINE_HOLD = 2'd0,
    LINE_DATA = 2'd1,
    LINE_WRAP = 2'd2
  } line_mode_e;

  // Fill level after one cycle of accepted writes and reads.
  function automatic int unsigned level_after(input int unsigned lvl,
                                              input logic wr,
                                              input logic rd);
    return lvl + 32'(wr) - 32'(rd);
  endfunction

  // Hold state wins over wrap; wrap wins over data.
  function automatic line_mode_e pick_mode(input logic in_rst,
                                           input logic locked,
                                           input logic wrap);
    if (in_rst || !locked) return LINE_HOLD;
    if (wrap) return LINE_WRAP;
    return LINE_DATA;
  endfunction

endpackage

// File: rtl/ser_word_fifo.sv
module ser_word_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  parameter int PRIME = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         rd_stb,
  output logic [W-1:0] rd_data,
  output logic         err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_FULL  = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_PRIME = LW'(PRIME);
  localparam logic [PW-1:0] PTR_LAST  = PW'(DEPTH - 1);
  localparam logic [PW-1:0] PTR_PRIME = PW'(PRIME % DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl, lvl_nxt;
  logic          wr_ok, rd_ok, lvl_edge;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign wr_ok    = wr_stb && (lvl != LVL_FULL);
  assign rd_ok    = rd_stb && (lvl != '0);
  assign lvl_nxt  = LW'(ser_tx_pkg::level_after(32'(lvl), wr_ok, rd_ok));
  assign lvl_edge = (wr_ok || rd_ok) && ((lvl_nxt == '0) || (lvl_nxt == LVL_FULL));
  assign rd_data  = rd_ok ? mem[rp] : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr) mem[i] <= '0;
      else if (wr_ok && (wp == PW'(i))) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= PTR_PRIME;
      rp  <= '0;
      lvl <= LVL_PRIME;
      err <= 1'b0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      lvl <= lvl_nxt;
      err <= err | lvl_edge;
    end
  end

  // R3
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (lvl == LVL_FULL) && !clr) |=> $stable(wp));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_FULL);
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_word,
  output logic         ser_bit
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] GAP_TOP = CW'(W - 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] gap;
  logic          seen_ld;
  logic          load_evt;

  assign load_evt = ld_stb && !clr;
  assign ser_bit  = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) shreg <= '0;
    else if (load_evt) shreg <= ld_word;
    else shreg <= shreg >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      gap     <= '0;
      seen_ld <= 1'b0;
    end else if (load_evt) begin
      gap     <= '0;
      seen_ld <= 1'b1;
    end else if (gap != GAP_TOP) begin
      gap <= gap + 1'b1;
    end
  end

  // R2
  load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && seen_ld) |-> (gap == GAP_TOP));
endmodule

// File: rtl/ser_line_ctrl.sv
module ser_line_ctrl
  import ser_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_rst,
  input  logic pll_lock,
  input  logic wrap_en,
  input  logic ser_bit,
  output logic line_p,
  output logic line_n,
  output logic wrap_ser,
  output logic locked
);
  line_mode_e mode;

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else if (pll_lock) locked <= 1'b1;
  end

  assign mode = pick_mode(tx_rst, locked, wrap_en);

  always_comb begin
    line_p   = 1'b0;
    line_n   = 1'b1;
    wrap_ser = 1'b0;
    case (mode)
      LINE_DATA: begin
        line_p = ser_bit;
        line_n = ~ser_bit;
      end
      LINE_WRAP: begin
        line_p   = 1'b1;
        line_n   = 1'b1;
        wrap_ser = ser_bit;
      end
      default: ;
    endcase
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  parameter int PRIME = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_stb,
  input  logic [W-1:0] tx_word,
  input  logic         ld_stb,
  input  logic         tx_rst,
  input  logic         pll_lock,
  input  logic         wrap_en,
  output logic         line_p,
  output logic         line_n,
  output logic         wrap_ser,
  output logic         fifo_err
);
  logic [W-1:0] q_word;
  logic         ser_bit;
  logic         locked;

  ser_word_fifo #(.W(W), .DEPTH(DEPTH), .PRIME(PRIME)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst),
    .wr_stb(cap_stb), .wr_data(tx_word),
    .rd_stb(ld_stb), .rd_data(q_word), .err(fifo_err)
  );

  ser_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst),
    .ld_stb(ld_stb), .ld_word(q_word), .ser_bit(ser_bit)
  );

  ser_line_ctrl u_line (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .pll_lock(pll_lock),
    .wrap_en(wrap_en), .ser_bit(ser_bit),
    .line_p(line_p), .line_n(line_n), .wrap_ser(wrap_ser), .locked(locked)
  );

  // R6
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |-> (!line_p && line_n && !wrap_ser));
  // R8
  unlocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!line_p && line_n));
  // R5
  wrap_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wrap_en && !tx_rst) |-> (line_p && line_n && (wrap_ser == ser_bit)));
  // R2
  data_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wrap_en && !tx_rst) |-> ((line_p == ser_bit) && (line_n != ser_bit) && !wrap_ser));
endmodule

// File: tb/ser_tx_top_bench.sv
`timescale 1ns/100ps
module ser_tx_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_stb = 1'b0, ld_stb = 1'b0;
  logic [9:0] tx_word = '0;
  logic       tx_rst = 1'b0, pll_lock = 1'b0, wrap_en = 1'b0;
  logic       line_p, line_n, wrap_ser, fifo_err;

  int  n_checks = 0;
  int  n_err = 0;
  bit  mon_on = 1'b0;
  bit  arm = 1'b0;
  bit  exp_bits[$];

  always #2 clk = ~clk;

  ser_tx_top u_ser_tx_top (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .tx_word(tx_word),
    .ld_stb(ld_stb), .tx_rst(tx_rst), .pll_lock(pll_lock), .wrap_en(wrap_en),
    .line_p(line_p), .line_n(line_n), .wrap_ser(wrap_ser), .fifo_err(fifo_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) exp_bits.push_back(1'b0);
  endtask

  task automatic push_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) exp_bits.push_back(w[i]);
  endtask

  // One ten-cycle word period; strobes high in its first cycle.
  task automatic period(input bit cap, input bit ld, input logic [9:0] w);
    @(negedge clk);
    cap_stb = cap; ld_stb = ld; tx_word = w;
    @(posedge clk);
    if (ld && arm) begin mon_on = 1'b1; arm = 1'b0; end
    @(negedge clk);
    cap_stb = 1'b0; ld_stb = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  // Scoreboard monitor: one expected bit per cycle after the first load.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (mon_on && exp_bits.size() > 0) begin
        bit b;
        b = exp_bits.pop_front();
        if (wrap_en)
          chk(line_p && line_n && (wrap_ser == b), "R5 wrap stream",
              {line_p, line_n, wrap_ser}, {2'b11, b});
        else
          chk((line_p == b) && (line_n == !b) && !wrap_ser, "R2 data bit",
              {line_p, line_n, wrap_ser}, {b, !b, 1'b0});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [9:0] words [8];
    words = '{10'h17C, 10'h283, 10'h3FF, 10'h000, 10'h155, 10'h2AA, 10'h0F1, 10'h30E};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sample();
    chk(!line_p && line_n, "R7 hold after reset", {line_p, line_n}, 1);
    chk(!fifo_err, "R1 no error after reset", fifo_err, 0);

    // Unlocked hold beats wrap, then lock makes wrap visible.
    @(negedge clk); wrap_en = 1'b1;
    sample();
    chk(!line_p && line_n, "R8 unlocked over wrap", {line_p, line_n}, 1);
    @(negedge clk); pll_lock = 1'b1;
    sample();
    chk(line_p && line_n, "R7 lock releases hold", {line_p, line_n}, 3);
    @(negedge clk); wrap_en = 1'b0;

    // Steady stream: two primed zero words, then data, wrap in the middle.
    push_zeros(20);
    arm = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (k == 3) wrap_en = 1'b1;
      if (k == 5) wrap_en = 1'b0;
      if (k == 6) pll_lock = 1'b0;   // R7 lock stays remembered
      push_word(words[k]);
      period(1'b1, 1'b1, words[k]);
    end
    period(1'b1, 1'b1, 10'h000);
    period(1'b1, 1'b1, 10'h000);
    @(negedge clk);
    chk(exp_bits.size() == 0, "R1 stream drained", exp_bits.size(), 0);
    chk(!fifo_err, "R4 balanced stream no error", fifo_err, 0);
    mon_on = 1'b0;
    exp_bits.delete();

    // Transmit reset with wrap requested.
    @(negedge clk); wrap_en = 1'b1; tx_rst = 1'b1;
    sample();
    chk(!line_p && line_n && !wrap_ser, "R6 reset hold over wrap",
        {line_p, line_n, wrap_ser}, 2);
    @(negedge clk); wrap_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); tx_rst = 1'b0;

    // Fill to full, drop one, then drain past empty.
    period(1'b1, 1'b0, 10'h2C3);
    chk(!fifo_err, "R4 level three", fifo_err, 0);
    period(1'b1, 1'b0, 10'h0B5);
    chk(fifo_err, "R4 full sets error", fifo_err, 1);
    period(1'b1, 1'b0, 10'h3E7);
    chk(fifo_err, "R4 error sticky", fifo_err, 1);
    push_zeros(20);
    push_word(10'h2C3);
    push_word(10'h0B5);
    push_zeros(10);   // R3 dropped word absent, empty load gives zeros
    arm = 1'b1;
    repeat (5) period(1'b0, 1'b1, 10'h000);
    @(negedge clk); @(negedge clk);
    chk(exp_bits.size() == 0, "R3 drop and empty-load", exp_bits.size(), 0);
    mon_on = 1'b0;
    exp_bits.delete();

    // Transmit reset clears error; underflow alone sets it.
    @(negedge clk); tx_rst = 1'b1;
    sample();
    chk(!fifo_err, "R6 tx_rst clears error", fifo_err, 0);
    @(negedge clk); tx_rst = 1'b0;
    period(1'b0, 1'b1, 10'h000);
    chk(!fifo_err, "R4 level one", fifo_err, 0);
    period(1'b0, 1'b1, 10'h000);
    chk(fifo_err, "R4 empty sets error", fifo_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule